// File: doc/BRIEF.md
# Threshold-Driven Transfer Initiation Controller

This block decides when the serial engine of a quad serial flash interface begins a transfer. Software programs two 6-bit byte thresholds through a small register port, one for each direction. The block compares them against the fill levels of the transmit and receive buffers and issues a one-cycle start pulse with a byte count. The direction it considers is chosen by a mode input.

In transmit-initiation mode a transmit starts once enough bytes are queued. In receive-initiation mode the block keeps the receive buffer topped up to the threshold: every time software drains bytes, it starts a new fetch for the difference. A fetch that would not fit in the free space of the buffer is never started. In execute-in-place mode the fetch target is the system bus burst size rather than the programmed threshold. Idle mode stops all initiation, so software can drain the receive buffer without new data arriving.

Only one transfer is outstanding at a time. After a start pulse the block waits until the engine raises its busy signal and then drops it again. In 16-bit mode an odd threshold is flagged and rounded up to the next even count. A change to the receive threshold while a receive is active is refused and recorded in a sticky flag.

Top module: `xfer_init_ctrl`

## Requirements
- R1: After reset `cfg_rd_data` is 0. A write stores bits 13:8 as the transmit threshold and bits 5:0 as the receive threshold, and all other read-back bits are 0. Writing 0xFFFF in idle mode reads back 0x3F3F.
- R2: With `mode` = 1 (transmit-initiation), a non-zero transmit threshold T and `tx_level` >= T at a rising edge, `start_tx` is high for the following cycle with `start_len` = T. No start occurs while `tx_level` < T.
- R3: With `mode` = 2 (receive-initiation), a non-zero receive threshold T and `rx_level` < T, a `start_rx` pulse is issued with `start_len` = T - `rx_level`.
- R4: No receive fetch starts when its length exceeds the free space, which is RX_DEPTH - `rx_level`. A fetch that exactly fills the buffer does start.
- R5: When `rx_level` drops below T in receive-initiation mode, a new fetch of T - `rx_level` bytes is started to refill the buffer.
- R6: With `mode` = 0 (idle), no start pulse of either kind is issued, whatever the levels.
- R7: With `mode` = 3 (execute-in-place), the receive target is `burst_len` instead of the receive threshold.
- R8: A threshold of 0, or `burst_len` = 0 in mode 3, disables initiation in that direction, and no start has `start_len` = 0.
- R9: With `wide_mode` = 1, `th_odd_err` is 1 while either stored threshold is odd, and an odd threshold is used as the next even value. With `wide_mode` = 0, `th_odd_err` is 0.
- R10: `start_tx` and `start_rx` are never high together. No start is issued in the cycle after a cycle in which `eng_busy` was high or a previous start was still waiting for `eng_busy` to rise.
- R11: While a receive is active, a write whose receive field differs from the stored value leaves the receive threshold unchanged and sets `rx_wr_err`, which stays set until reset. A receive is active when `mode` is 2 or 3, or a receive transfer is in flight. The transmit field of that write is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Threshold register write strobe |
| cfg_wr_data | input | 16 | Threshold register write data |
| cfg_rd_data | output | 16 | Threshold register read-back |
| mode | input | 2 | 0 idle, 1 transmit-initiation, 2 receive-initiation, 3 execute-in-place |
| wide_mode | input | 1 | 16-bit transfer mode |
| tx_level | input | CNT_W | Bytes held in the transmit buffer |
| rx_level | input | CNT_W | Bytes held in the receive buffer |
| burst_len | input | TH_W+1 | System bus burst size used in mode 3 |
| eng_busy | input | 1 | Serial engine is running a transfer |
| start_tx | output | 1 | One-cycle transmit start pulse |
| start_rx | output | 1 | One-cycle receive start pulse |
| start_len | output | TH_W+1 | Byte count for the started transfer |
| th_odd_err | output | 1 | Odd threshold seen in 16-bit mode |
| rx_wr_err | output | 1 | Sticky: receive threshold write refused |

## Verification
The bench builds the block with TH_W = 6, CNT_W = 6 and RX_DEPTH = 32. This buffer is smaller than the largest threshold, so a threshold of 40 is refused for lack of space, while a threshold of 32 fills an empty buffer exactly. The bench's engine model raises busy one cycle after each start pulse, which puts the window between a start and the busy acknowledge within reach of the checks. Refill, execute-in-place and 16-bit rounding are each driven with a target that differs from the other sources of length, so a wrong length source shows up as a length mismatch.

// File: rtl/xfer_init_pkg.sv
package xfer_init_pkg;

  typedef enum logic [1:0] {
    XI_IDLE = 2'd0,
    XI_TX   = 2'd1,
    XI_RX   = 2'd2,
    XI_XIP  = 2'd3
  } xi_mode_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_TX   = 2'd1,
    DIR_RX   = 2'd2
  } xi_dir_e;

endpackage

// File: rtl/xfer_init_cfg.sv
module xfer_init_cfg #(
  parameter int TH_W   = 6,
  parameter int REG_W  = 16,
  parameter int TX_LSB = 8,
  parameter int RX_LSB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rx_active,
  input  logic             wide,
  output logic [TH_W-1:0]  tx_th,
  output logic [TH_W-1:0]  rx_th,
  output logic [REG_W-1:0] rd_data,
  output logic             odd_err,
  output logic             rx_wr_err
);

  logic [TH_W-1:0] tx_th_q, rx_th_q;
  logic [TH_W-1:0] wr_rx_field;
  logic            rx_wr_refused;
  logic            rx_wr_err_q;

  assign wr_rx_field   = wr_data[RX_LSB +: TH_W];
  // event: a receive threshold change arrives while a receive is active
  assign rx_wr_refused = wr_en && rx_active && (wr_rx_field != rx_th_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_th_q     <= '0;
      rx_th_q     <= '0;
      rx_wr_err_q <= 1'b0;
    end else begin
      if (wr_en) begin
        tx_th_q <= wr_data[TX_LSB +: TH_W];
        if (!rx_active) rx_th_q <= wr_rx_field;
      end
      if (rx_wr_refused) rx_wr_err_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[TX_LSB +: TH_W]  = tx_th_q;
    rd_data[RX_LSB +: TH_W]  = rx_th_q;
  end

  assign tx_th     = tx_th_q;
  assign rx_th     = rx_th_q;
  assign odd_err   = wide && (tx_th_q[0] || rx_th_q[0]);
  assign rx_wr_err = rx_wr_err_q;

  assert_rx_th_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rx_active) |=> $stable(rx_th_q));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_err_q |=> rx_wr_err_q);

  assert_err_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_refused |=> rx_wr_err_q);

endmodule

// File: rtl/xfer_init_tx_plan.sv
module xfer_init_tx_plan #(
  parameter int TH_W  = 6,
  parameter int CNT_W = 6,
  localparam int LEN_W = TH_W + 1,
  localparam int CMP_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1
) (
  input  logic             active,
  input  logic             wide,
  input  logic [TH_W-1:0]  tx_th,
  input  logic [CNT_W-1:0] tx_level,
  output logic             want,
  output logic [LEN_W-1:0] len
);

  // threshold as used: rounded up to even in 16-bit mode
  function automatic logic [LEN_W-1:0] eff_len(input logic [TH_W-1:0] th,
                                               input logic wide_i);
    eff_len = {1'b0, th} + LEN_W'(wide_i & th[0]);
  endfunction

  logic [CMP_W-1:0] lvl_w, len_w;

  assign len   = eff_len(tx_th, wide);
  assign lvl_w = CMP_W'(tx_level);
  assign len_w = CMP_W'(len);
  assign want  = active && (tx_th != '0) && (lvl_w >= len_w);

endmodule

// File: rtl/xfer_init_rx_plan.sv
module xfer_init_rx_plan #(
  parameter int TH_W     = 6,
  parameter int CNT_W    = 6,
  parameter int RX_DEPTH = 32,
  localparam int LEN_W = TH_W + 1,
  localparam int CMP_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1
) (
  input  logic             active,
  input  logic             use_burst,
  input  logic             wide,
  input  logic [TH_W-1:0]  rx_th,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [CNT_W-1:0] rx_level,
  output logic             want,
  output logic [LEN_W-1:0] need
);

  function automatic logic [LEN_W-1:0] eff_len(input logic [TH_W-1:0] th,
                                               input logic wide_i);
    eff_len = {1'b0, th} + LEN_W'(wide_i & th[0]);
  endfunction

  // free space, saturating at zero if the level ever exceeds the depth
  function automatic logic [CMP_W-1:0] free_space(input logic [CMP_W-1:0] lvl);
    logic [CMP_W-1:0] depth;
    depth = CMP_W'(RX_DEPTH);
    free_space = (lvl > depth) ? '0 : (depth - lvl);
  endfunction

  logic [LEN_W-1:0] target;
  logic [CMP_W-1:0] lvl_w, free_w, tgt_w;
  logic             below;
  logic             fits;

  assign target = use_burst ? burst_len : eff_len(rx_th, wide);
  assign lvl_w  = CMP_W'(rx_level);
  assign tgt_w  = CMP_W'(target);
  assign free_w = free_space(lvl_w);
  assign below  = lvl_w < tgt_w;
  // below guarantees the level fits in LEN_W bits
  assign need   = target - lvl_w[LEN_W-1:0];
  assign fits   = free_w >= CMP_W'(need);
  assign want   = active && (target != '0) && below && fits;

endmodule

// File: rtl/xfer_init_launch.sv
module xfer_init_launch
  import xfer_init_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_want,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             rx_want,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             eng_busy,
  output logic             start_tx,
  output logic             start_rx,
  output logic [LEN_W-1:0] start_len,
  output logic             rx_inflight
);

  logic             start_tx_q, start_rx_q;
  logic [LEN_W-1:0] start_len_q;
  logic             wait_q;
  xi_dir_e          dir_q;
  logic             gate_open, launch_tx, launch_rx, launch_any;

  assign gate_open  = !eng_busy && !wait_q;
  assign launch_tx  = gate_open && tx_want;
  assign launch_rx  = gate_open && rx_want && !tx_want;
  assign launch_any = launch_tx || launch_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_tx_q  <= 1'b0;
      start_rx_q  <= 1'b0;
      start_len_q <= '0;
      wait_q      <= 1'b0;
      dir_q       <= DIR_NONE;
    end else begin
      start_tx_q <= launch_tx;
      start_rx_q <= launch_rx;
      if (launch_any) begin
        start_len_q <= launch_tx ? tx_len : rx_len;
        dir_q       <= launch_tx ? DIR_TX : DIR_RX;
        wait_q      <= 1'b1;
      end else if (eng_busy) begin
        wait_q <= 1'b0;
      end
    end
  end

  assign start_tx    = start_tx_q;
  assign start_rx    = start_rx_q;
  assign start_len   = start_len_q;
  assign rx_inflight = (dir_q == DIR_RX) && (wait_q || eng_busy);

  assert_one_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_tx_q, start_rx_q}));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy || wait_q) |=> !(start_tx_q || start_rx_q));

  assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_tx_q || start_rx_q) |-> (start_len_q != '0));

endmodule

// File: rtl/xfer_init_ctrl.sv
module xfer_init_ctrl
  import xfer_init_pkg::*;
#(
  parameter int TH_W     = 6,
  parameter int CNT_W    = 6,
  parameter int RX_DEPTH = 32,
  localparam int LEN_W  = TH_W + 1,
  localparam int REG_W  = 16,
  localparam int CMP_W  = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic [1:0]       mode,
  input  logic             wide_mode,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             eng_busy,
  output logic             start_tx,
  output logic             start_rx,
  output logic [LEN_W-1:0] start_len,
  output logic             th_odd_err,
  output logic             rx_wr_err
);

  xi_mode_e         mode_e;
  logic             tx_mode, rx_mode, xip_mode, rx_active, rx_inflight;
  logic [TH_W-1:0]  tx_th, rx_th;
  logic             tx_want, rx_want;
  logic [LEN_W-1:0] tx_len, rx_len;

  assign mode_e    = xi_mode_e'(mode);
  assign tx_mode   = (mode_e == XI_TX);
  assign rx_mode   = (mode_e == XI_RX);
  assign xip_mode  = (mode_e == XI_XIP);
  assign rx_active = rx_mode || xip_mode || rx_inflight;

  xfer_init_cfg #(.TH_W(TH_W), .REG_W(REG_W), .TX_LSB(8), .RX_LSB(0)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .rx_active (rx_active),
    .wide      (wide_mode),
    .tx_th     (tx_th),
    .rx_th     (rx_th),
    .rd_data   (cfg_rd_data),
    .odd_err   (th_odd_err),
    .rx_wr_err (rx_wr_err)
  );

  xfer_init_tx_plan #(.TH_W(TH_W), .CNT_W(CNT_W)) tx_plan_i (
    .active   (tx_mode),
    .wide     (wide_mode),
    .tx_th    (tx_th),
    .tx_level (tx_level),
    .want     (tx_want),
    .len      (tx_len)
  );

  xfer_init_rx_plan #(.TH_W(TH_W), .CNT_W(CNT_W), .RX_DEPTH(RX_DEPTH)) rx_plan_i (
    .active    (rx_mode || xip_mode),
    .use_burst (xip_mode),
    .wide      (wide_mode),
    .rx_th     (rx_th),
    .burst_len (burst_len),
    .rx_level  (rx_level),
    .want      (rx_want),
    .need      (rx_len)
  );

  xfer_init_launch #(.LEN_W(LEN_W)) launch_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_want     (tx_want),
    .tx_len      (tx_len),
    .rx_want     (rx_want),
    .rx_len      (rx_len),
    .eng_busy    (eng_busy),
    .start_tx    (start_tx),
    .start_rx    (start_rx),
    .start_len   (start_len),
    .rx_inflight (rx_inflight)
  );

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == XI_IDLE) |=> !(start_tx || start_rx));

  assert_fetch_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_rx |-> (CMP_W'(start_len) + CMP_W'($past(rx_level)) <= CMP_W'(RX_DEPTH)));

  assert_tx_needs_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |=> !start_tx);

endmodule

// File: tb/xfer_init_ctrl_tb_top.sv
module xfer_init_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TH_W       = 6;
  localparam int CNT_W      = 6;
  localparam int RX_DEPTH   = 32;
  localparam int LEN_W      = TH_W + 1;
  localparam int BUSY_CYC   = 3;
  localparam int WD_LIMIT   = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr_en = 1'b0;
  logic [15:0]      cfg_wr_data = '0;
  logic [15:0]      cfg_rd_data;
  logic [1:0]       mode = 2'd0;
  logic             wide_mode = 1'b0;
  logic [CNT_W-1:0] tx_level = '0;
  logic [CNT_W-1:0] rx_level = '0;
  logic [LEN_W-1:0] burst_len = '0;
  logic             eng_busy = 1'b0;
  logic             start_tx, start_rx;
  logic [LEN_W-1:0] start_len;
  logic             th_odd_err, rx_wr_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_init_ctrl #(.TH_W(TH_W), .CNT_W(CNT_W), .RX_DEPTH(RX_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .mode(mode), .wide_mode(wide_mode),
    .tx_level(tx_level), .rx_level(rx_level), .burst_len(burst_len),
    .eng_busy(eng_busy), .start_tx(start_tx), .start_rx(start_rx),
    .start_len(start_len), .th_odd_err(th_odd_err), .rx_wr_err(rx_wr_err)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    exp_q[$];
  string exp_tag[$];
  logic  eng_pend = 1'b0;
  int    eng_cnt = 0;
  int    eng_dir = 0;
  int    eng_len = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // dir: 1 transmit, 2 receive
  task automatic expect_start(input int dir, input int len, input string tag);
    exp_q.push_back(dir * 256 + len);
    exp_tag.push_back(tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic drained(input string tag);
    cyc(24);
    chk(tag, exp_q.size(), 0);
    exp_q.delete();
    exp_tag.delete();
  endtask

  // engine model and scoreboard monitor, both on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (eng_busy) begin
        eng_cnt--;
        if (eng_cnt == 0) begin
          if (eng_dir == 1) tx_level = tx_level - CNT_W'(eng_len);
          else              rx_level = rx_level + CNT_W'(eng_len);
          eng_busy = 1'b0;
        end
      end else if (eng_pend) begin
        eng_pend = 1'b0;
        eng_busy = 1'b1;
        eng_cnt  = BUSY_CYC;
      end
      if (start_tx || start_rx) begin
        int    got;
        int    e;
        string t;
        got = (start_tx ? 256 : 512) + int'(start_len);
        if (eng_busy && eng_cnt != BUSY_CYC) begin
          n_cmp++; n_bad++;
          $display("FAIL R10 start during busy actual=0x%0h expected=none", got);
        end
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R6/R10 unexpected start actual=0x%0h expected=none", got);
        end else begin
          e = exp_q.pop_front();
          t = exp_tag.pop_front();
          if (e != got) begin
            n_bad++;
            $display("FAIL %s start actual=0x%0h expected=0x%0h", t, got, e);
          end
        end
        eng_pend = 1'b1;
        eng_dir  = start_tx ? 1 : 2;
        eng_len  = int'(start_len);
      end
    end
  end

  logic done = 1'b0;

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // reset state R1
    chk("R1 reset rd", int'(cfg_rd_data), 0);
    chk("R10 reset start_tx", int'(start_tx), 0);
    chk("R10 reset start_rx", int'(start_rx), 0);
    chk("R11 reset err", int'(rx_wr_err), 0);
    chk("R9 reset odd", int'(th_odd_err), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);

    // R1 field placement, R6 idle with large threshold
    wr_cfg(16'hFFFF);
    chk("R1 readback", int'(cfg_rd_data), 16'h3F3F);
    drained("R6 idle no start");

    // R2 transmit threshold 4
    wr_cfg(16'h0400);
    mode = 2'd1;
    tx_level = 6'd2;
    drained("R2 below threshold");
    expect_start(1, 4, "R2 tx start");
    tx_level = 6'd5;
    drained("R2 single tx");
    chk("R2 tx level after", int'(tx_level), 1);
    expect_start(1, 4, "R2 tx first");
    expect_start(1, 4, "R10 tx second after busy");
    tx_level = 6'd8;
    drained("R10 two tx");

    // R8 transmit threshold 0 disables
    wr_cfg(16'h0000);
    tx_level = 6'd10;
    drained("R8 tx zero threshold");

    // R3 receive threshold 6
    mode = 2'd0;
    tx_level = '0;
    wr_cfg(16'h0006);
    expect_start(2, 6, "R3 rx fetch");
    mode = 2'd2;
    drained("R3 rx initial");
    chk("R3 rx level", int'(rx_level), 6);
    // R5 refill after software reads 4 bytes
    expect_start(2, 4, "R5 refill");
    rx_level = 6'd2;
    drained("R5 refill");

    // R11 refused write while receiving
    wr_cfg(16'h000A);
    chk("R11 rx field kept", int'(cfg_rd_data), 16'h0006);
    chk("R11 err set", int'(rx_wr_err), 1);
    wr_cfg(16'h0106);
    chk("R11 tx field still written", int'(cfg_rd_data), 16'h0106);

    // R6 idle: drain, no fetch
    mode = 2'd0;
    cyc(2);
    rx_level = '0;
    drained("R6 idle after drain");
    chk("R11 err sticky", int'(rx_wr_err), 1);

    // R4 no space for 40 in a 32-byte buffer
    wr_cfg(16'h0028);
    mode = 2'd2;
    drained("R4 no fit");
    mode = 2'd0;
    wr_cfg(16'h0020);
    expect_start(2, 32, "R4 exact fit");
    mode = 2'd2;
    drained("R4 exact fit");

    // R7 execute-in-place uses burst length
    mode = 2'd0;
    cyc(2);
    rx_level = '0;
    burst_len = 7'd16;
    expect_start(2, 16, "R7 burst fetch");
    mode = 2'd3;
    drained("R7 burst");
    // R8 burst zero disables
    mode = 2'd0;
    cyc(2);
    rx_level = '0;
    burst_len = '0;
    mode = 2'd3;
    drained("R8 burst zero");

    // R9 wide mode odd threshold
    mode = 2'd0;
    cyc(2);
    wr_cfg(16'h0005);
    wide_mode = 1'b1;
    cyc(1);
    chk("R9 odd flag", int'(th_odd_err), 1);
    expect_start(2, 6, "R9 rounded fetch");
    mode = 2'd2;
    drained("R9 rounded");
    mode = 2'd0;
    wide_mode = 1'b0;
    cyc(1);
    chk("R9 flag off narrow", int'(th_odd_err), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule